// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 28 interrupt request lines, numbered 0 to 27, and turns them into one service decision per cycle. A rising edge on a request line, or a software trigger write, sets a sticky pending flag for that line. A per-line enable mask then filters the pending flags. Lines 0 and 1 pass the filter whatever the mask says. From the remaining candidates the block picks one line using a fixed rank table that does not follow the line numbers.

The block registers the chosen line number, a valid flag and a complete vector address. The address is the sum of a per-line byte offset and one of two programmable base registers. Lines 16 to 23 use the second base and every other line uses the first. Line 0 is the reset slot and line 1 is the non-maskable slot. The external request for line 1 is held inactive inside the block, so line 1 can only be raised through the software trigger.

A simple write port loads the mask and the two bases and issues software triggers. A one-cycle acknowledge with a line number clears that line's pending flag once the line has been serviced.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, sel_valid, sel_index and vec_addr are 0. Reset also clears the mask, both bases and every pending flag.
- R2: A 0-to-1 transition on irq_in[i] sets pending flag i, and the flag stays set until it is acknowledged. Keeping irq_in[i] high after the acknowledge does not set the flag again; only a new rising edge does.
- R3: A cycle with ack_valid=1 and ack_index=i clears pending flag i. If a rising edge or a software trigger for line i arrives in that same cycle, flag i stays set. An ack_index of 28 or more has no effect.
- R4: A pending line i with i>=2 is a candidate only when mask bit i is 1. Lines 0 and 1 are candidates whenever they are pending, whatever the mask holds.
- R5: The chosen line is the candidate with the smallest rank. A smaller rank means a higher priority. The ranks for lines 0 to 27 are 0,1,3,5,6,7,9,10,11,13,14,15,17,18,21,22,4,8,12,16,19,20,23,24,2,25,26,14.
- R6: When two candidates have the same rank, the lower line number wins, so line 10 beats line 27.
- R7: vec_addr = base + 8*sel_index. For lines 16 to 23 the base is the high base register; for every other line it is the low base register.
- R8: The block never acts on irq_in[1]. Writing register 3 sets the pending flag of every line whose wdata bit is 1, and that includes line 1.
- R9: The outputs are registered. A change in the pending flags, the mask or a base register that happens at one clock edge shows on the outputs at the next clock edge.
- R10: Register writes happen when reg_we=1. reg_addr selects the target: 0 = mask (wdata[27:0]), 1 = low base, 2 = high base, 3 = software trigger.
- R11: When there is no candidate, sel_valid, sel_index and vec_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 28 | Request lines, edge sensitive; bit 1 is ignored |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_index | input | 5 | Line number being acknowledged |
| sel_valid | output | 1 | A candidate is selected |
| sel_index | output | 5 | Selected line number |
| vec_addr | output | 32 | Vector address of the selected line |

## Verification
Two functions can meet in one cycle: the acknowledge that clears a flag and a new rising edge (or software trigger) that sets the same flag. The bench first lets a line's request fall. It then drives the acknowledge and the new rising edge on the same clock edge. The line must still be selected two cycles later. A random phase also mixes edges, acknowledges of the line currently shown on the outputs, mask rewrites and triggers, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_LINES  = 28;
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int RANK_W     = 5;
    localparam int ADDR_W     = 32;
    localparam int VEC_SHIFT  = 3;
    localparam int HI_FIRST   = 16;
    localparam int HI_LAST    = 23;
    localparam int RESET_LINE = 0;
    localparam int NMI_LINE   = 1;
    localparam int REGSEL_W   = 2;

    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [RANK_W-1:0]    rank_t;
    typedef logic [NUM_LINES-1:0] lines_t;
    typedef logic [ADDR_W-1:0]    addr_t;

    typedef enum logic [REGSEL_W-1:0] {
        REG_MASK    = 2'd0,
        REG_BASE_LO = 2'd1,
        REG_BASE_HI = 2'd2,
        REG_TRIGGER = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        idx_t index;
    } pick_t;

    typedef struct packed {
        lines_t mask;
        addr_t  base_lo;
        addr_t  base_hi;
    } cfg_t;

    function automatic rank_t line_rank(idx_t i);
        rank_t r;
        case (i)
            5'd0:  r = 5'd0;
            5'd1:  r = 5'd1;
            5'd2:  r = 5'd3;
            5'd3:  r = 5'd5;
            5'd4:  r = 5'd6;
            5'd5:  r = 5'd7;
            5'd6:  r = 5'd9;
            5'd7:  r = 5'd10;
            5'd8:  r = 5'd11;
            5'd9:  r = 5'd13;
            5'd10: r = 5'd14;
            5'd11: r = 5'd15;
            5'd12: r = 5'd17;
            5'd13: r = 5'd18;
            5'd14: r = 5'd21;
            5'd15: r = 5'd22;
            5'd16: r = 5'd4;
            5'd17: r = 5'd8;
            5'd18: r = 5'd12;
            5'd19: r = 5'd16;
            5'd20: r = 5'd19;
            5'd21: r = 5'd20;
            5'd22: r = 5'd23;
            5'd23: r = 5'd24;
            5'd24: r = 5'd2;
            5'd25: r = 5'd25;
            5'd26: r = 5'd26;
            5'd27: r = 5'd14;
            default: r = '1;
        endcase
        return r;
    endfunction

    function automatic logic uses_hi_base(idx_t i);
        return (int'(i) >= HI_FIRST) && (int'(i) <= HI_LAST);
    endfunction

    function automatic addr_t vec_offset(idx_t i);
        return addr_t'(i) << VEC_SHIFT;
    endfunction

    function automatic lines_t unmaskable();
        lines_t m;
        m = '0;
        m[RESET_LINE] = 1'b1;
        m[NMI_LINE]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    parameter int AW    = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REGSEL_W-1:0] addr,
    input  logic [AW-1:0]       wdata,
    output cfg_t                cfg,
    output lines_t              sw_set
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                REG_MASK:    cfg.mask    <= wdata[LINES-1:0];
                REG_BASE_LO: cfg.base_lo <= wdata;
                REG_BASE_HI: cfg.base_hi <= wdata;
                default:     ;
            endcase
        end
    end

    assign sw_set = (we && sel == REG_TRIGGER) ? wdata[LINES-1:0] : '0;

endmodule

// File: rtl/irqv_pending.sv
module irqv_pending
    import irqv_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t irq_in,
    input  lines_t sw_set,
    input  logic   ack_valid,
    input  idx_t   ack_index,
    output lines_t pending
);

    lines_t prev;
    lines_t set_vec;
    lines_t clr_vec;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= irq_in;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic ext_rise;
        if (i == NMI_LINE) begin : g_inert
            assign ext_rise = 1'b0;
        end else begin : g_edge
            assign ext_rise = irq_in[i] & ~prev[i];
        end
        assign set_vec[i] = ext_rise | sw_set[i];
        assign clr_vec[i] = ack_valid && (ack_index == idx_t'(i));

        always_ff @(posedge clk) begin
            if (rst) pending[i] <= 1'b0;
            else     pending[i] <= (pending[i] & ~clr_vec[i]) | set_vec[i];
        end

        a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
            (pending[i] && !(ack_valid && ack_index == idx_t'(i))) |=> pending[i]);

        a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_valid && ack_index == idx_t'(i) && !sw_set[i] &&
             !(irq_in[i] && !prev[i])) |=> !pending[i]);

        a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
            (sw_set[i]) |=> pending[i]);
    end

    a_r8_pin_inert: assert property (@(posedge clk) disable iff (rst)
        (!pending[NMI_LINE] && !sw_set[NMI_LINE]) |=> !pending[NMI_LINE]);

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
#(
    parameter int LINES = NUM_LINES
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t pending,
    input  lines_t mask,
    output pick_t  pick
);

    lines_t eligible;
    assign eligible = pending & (mask | unmaskable());

    always_comb begin
        rank_t best;
        pick = '0;
        best = '1;
        for (int i = 0; i < LINES; i++) begin
            if (eligible[i] && (!pick.valid || line_rank(idx_t'(i)) < best)) begin
                pick.valid = 1'b1;
                pick.index = idx_t'(i);
                best       = line_rank(idx_t'(i));
            end
        end
    end

    a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> |(eligible & (lines_t'(1) << pick.index)));

    for (genvar j = 0; j < LINES; j++) begin : g_cmp
        a_r5_rank: assert property (@(posedge clk) disable iff (rst)
            (pick.valid && eligible[j]) |->
                (line_rank(pick.index) <= line_rank(idx_t'(j))));

        a_r6_tie: assert property (@(posedge clk) disable iff (rst)
            (pick.valid && eligible[j] &&
             line_rank(pick.index) == line_rank(idx_t'(j))) |->
                (int'(pick.index) <= j));
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [27:0]         irq_in,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    input  logic                ack_valid,
    input  logic [4:0]          ack_index,
    output logic                sel_valid,
    output logic [4:0]          sel_index,
    output logic [31:0]         vec_addr
);

    cfg_t   cfg;
    lines_t sw_set;
    lines_t pending;
    pick_t  pick;
    addr_t  base;

    irqv_regs #(.LINES(NUM_LINES), .AW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cfg    (cfg),
        .sw_set (sw_set)
    );

    irqv_pending #(.LINES(NUM_LINES)) u_pending (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .sw_set    (sw_set),
        .ack_valid (ack_valid),
        .ack_index (ack_index),
        .pending   (pending)
    );

    irqv_arbiter #(.LINES(NUM_LINES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .mask    (cfg.mask),
        .pick    (pick)
    );

    assign base = uses_hi_base(pick.index) ? cfg.base_hi : cfg.base_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid <= 1'b0;
            sel_index <= '0;
            vec_addr  <= '0;
        end else begin
            sel_valid <= pick.valid;
            sel_index <= pick.valid ? pick.index : '0;
            vec_addr  <= pick.valid ? (base + vec_offset(pick.index)) : '0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sel_valid && sel_index == '0 && vec_addr == '0));

    a_r9_registered: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> $past(|pending));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> (sel_index == '0 && vec_addr == '0));

    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && $stable(cfg.base_lo) && $stable(cfg.base_hi) &&
         cfg.base_lo[2:0] == 3'b0 && cfg.base_hi[2:0] == 3'b0) |-> vec_addr[2:0] == 3'b0);

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_index = '0;
    logic        sel_valid;
    logic [4:0]  sel_index;
    logic [31:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R5";

    int rank_tab [N] = '{0,1,3,5,6,7,9,10,11,13,14,15,17,18,21,22,
                         4,8,12,16,19,20,23,24,2,25,26,14};

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ack_valid(ack_valid),
        .ack_index(ack_index), .sel_valid(sel_valid), .sel_index(sel_index),
        .vec_addr(vec_addr)
    );

    // behavioural reference model
    bit          m_pend [N];
    bit          m_prev [N];
    logic [27:0] m_mask;
    logic [31:0] m_blo, m_bhi;
    bit          e_valid;
    int          e_idx;
    logic [31:0] e_addr;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
            m_mask = '0; m_blo = '0; m_bhi = '0;
            e_valid = 0; e_idx = 0; e_addr = '0;
        end else begin
            int best;
            bit setb;
            bit clrb;
            best = -1;
            for (int i = 0; i < N; i++)
                if (m_pend[i] && (i < 2 || m_mask[i]))
                    if (best < 0 || rank_tab[i] < rank_tab[best]) best = i;
            e_valid = (best >= 0);
            e_idx   = (best >= 0) ? best : 0;
            if (best < 0) e_addr = '0;
            else e_addr = ((best >= 16 && best <= 23) ? m_bhi : m_blo) + 32'(best * 8);
            for (int i = 0; i < N; i++) begin
                clrb = ack_valid && (int'(ack_index) == i);
                setb = (i != 1 && irq_in[i] && !m_prev[i]) ||
                       (reg_we && reg_addr == 2'd3 && reg_wdata[i]);
                if (setb) m_pend[i] = 1;
                else if (clrb) m_pend[i] = 0;
                m_prev[i] = irq_in[i];
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_mask = reg_wdata[27:0];
                    2'd1: m_blo  = reg_wdata;
                    2'd2: m_bhi  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            checks++;
            if (sel_valid !== e_valid || int'(sel_index) != e_idx || vec_addr !== e_addr) begin
                errors++;
                $display("FAIL %s model: got v=%0b i=%0d a=%h expected v=%0b i=%0d a=%h",
                         cur_tag, sel_valid, sel_index, vec_addr, e_valid, e_idx, e_addr);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic ack(int i);
        ack_valid = 1'b1; ack_index = 5'(i);
        step(1);
        ack_valid = 1'b0;
    endtask

    task automatic expect_sel(string tag, bit v, int idx, logic [31:0] a);
        checks++;
        if (sel_valid !== v || int'(sel_index) != idx || vec_addr !== a) begin
            errors++;
            $display("FAIL %s: got v=%0b i=%0d a=%h expected v=%0b i=%0d a=%h",
                     tag, sel_valid, sel_index, vec_addr, v, idx, a);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_sel("R1 during reset", 0, 0, 32'h0);
        rst = 1'b0;
        model_on = 1'b1;
        step(1);
        expect_sel("R1 after reset", 0, 0, 32'h0);

        // R4: masked line stays invisible; R10 mask register
        cur_tag = "R4";
        irq_in[5] = 1'b1; step(2);
        expect_sel("R4 masked line", 0, 0, 32'h0);
        wr(2'd0, 32'h0FFF_FFFF); step(1);
        expect_sel("R10 mask write enables line 5", 1, 5, 32'h28);
        ack(5); step(1);
        expect_sel("R11 idle after ack", 0, 0, 32'h0);
        irq_in = '0; step(1);

        // R5 ranks
        cur_tag = "R5";
        irq_in[3] = 1'b1; irq_in[16] = 1'b1; step(2);
        expect_sel("R5 line16 over line3", 1, 16, 32'h80);
        ack(16); step(1);
        expect_sel("R5 line3 after 16", 1, 3, 32'h18);
        ack(3); step(1);
        irq_in = '0; step(1);
        irq_in[2] = 1'b1; irq_in[24] = 1'b1; step(2);
        expect_sel("R5 line24 over line2", 1, 24, 32'hC0);
        ack(24); step(1);
        expect_sel("R5 line2 next", 1, 2, 32'h10);
        ack(2); step(1);
        irq_in = '0; step(1);

        // R6 tie
        cur_tag = "R6";
        irq_in[10] = 1'b1; irq_in[27] = 1'b1; step(2);
        expect_sel("R6 line10 over line27", 1, 10, 32'h50);
        ack(10); step(1);
        expect_sel("R6 line27 after 10", 1, 27, 32'hD8);
        ack(27); step(2);
        expect_sel("R2 held level does not re-pend", 0, 0, 32'h0);
        irq_in = '0; step(1);

        // R7 bases
        cur_tag = "R7";
        wr(2'd1, 32'h4000_0000);
        wr(2'd2, 32'h0001_0000);
        irq_in[20] = 1'b1; step(2);
        expect_sel("R7 high base for line20", 1, 20, 32'h0001_00A0);
        ack(20); irq_in = '0; step(1);
        irq_in[4] = 1'b1; step(2);
        expect_sel("R7 low base for line4", 1, 4, 32'h4000_0020);
        ack(4); irq_in = '0; step(1);
        ack(30); step(1);
        expect_sel("R3 out-of-range ack harmless", 0, 0, 32'h0);

        // R8 inert pin, software trigger, unmaskable
        cur_tag = "R8";
        wr(2'd0, 32'h0);
        irq_in[1] = 1'b1; step(2);
        expect_sel("R8 pin for line1 ignored", 0, 0, 32'h0);
        wr(2'd3, 32'h0000_0002); step(1);
        expect_sel("R8 trigger raises line1 with mask 0", 1, 1, 32'h4000_0008);
        wr(2'd3, 32'h0000_0001); step(1);
        expect_sel("R4 line0 unmaskable and outranks 1", 1, 0, 32'h4000_0000);
        ack(0); ack(1); step(1);
        expect_sel("R3 cleared both", 0, 0, 32'h0);
        irq_in = '0;

        // R3 simultaneous ack and new edge
        cur_tag = "R3";
        wr(2'd0, 32'h0FFF_FFFF);
        irq_in[7] = 1'b1; step(2);
        expect_sel("R3 line7 raised", 1, 7, 32'h4000_0038);
        irq_in[7] = 1'b0; step(1);
        irq_in[7] = 1'b1; ack(7); step(1);
        expect_sel("R3 new edge with ack stays pending", 1, 7, 32'h4000_0038);
        ack(7); step(1);
        expect_sel("R3 plain ack clears", 0, 0, 32'h0);
        irq_in = '0; step(1);

        // R9 latency
        cur_tag = "R9";
        irq_in[9] = 1'b1; step(1);
        expect_sel("R9 not visible after one edge", 0, 0, 32'h0);
        step(1);
        expect_sel("R9 visible after two edges", 1, 9, 32'h4000_0048);
        wr(2'd0, 32'h0);
        expect_sel("R9 mask change not yet visible", 1, 9, 32'h4000_0048);
        step(1);
        expect_sel("R9 mask change visible", 0, 0, 32'h0);
        wr(2'd0, 32'h0FFF_FFFF);
        ack(9); irq_in = '0; step(2);

        // random mix compared against the model
        cur_tag = "R5";
        for (int k = 0; k < 2000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            irq_in = irq_in ^ (28'($urandom) & 28'($urandom) & 28'($urandom));
            if (r < 40 && sel_valid) begin
                ack_valid = 1'b1; ack_index = sel_index;
            end else if (r < 45) begin
                ack_valid = 1'b1; ack_index = 5'($urandom_range(0, 31));
            end else ack_valid = 1'b0;
            if (r >= 90 && r < 94) begin
                reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = $urandom;
            end else if (r >= 94 && r < 96) begin
                reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'(1 << $urandom_range(0, 27));
            end else if (r >= 96) begin
                reg_we = 1'b1; reg_addr = 2'($urandom_range(1, 2)); reg_wdata = $urandom;
            end else reg_we = 1'b0;
            step(1);
        end
        reg_we = 1'b0; ack_valid = 1'b0;
        step(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule